// File: doc/BRIEF.md
# UART-Driven Control Register File

This block sits behind a UART receiver and in front of a UART transmitter. A level input selects the meaning of each received byte. When the level is high the byte is payload and goes straight out on a data strobe. When the level is low the byte is a command. Its upper nibble names a 4-bit register and its lower nibble is the value to store there. A shadow bit held in one of the registers supplies a fifth address bit, which opens a second bank of sixteen registers.

The block can send each accepted command back to the host through the transmitter. A command to one fixed address returns a status nibble instead of storing anything. Two bits of a control register start actions rather than holding state: one applies the stored baud divisor, the other returns the whole file to its reset contents. When a byte is being sent back, both actions wait until the transmitter reports that the byte has left. The reply therefore goes out at the old rate.

A command that arrives while the transmitter is still busy is parked in a one-entry holding slot, so that back-to-back commands are not lost.

Top module: `uart_cfg_regfile`

## Requirements
- R1: A byte received while `dc_data` is 1 appears on `data_byte` with `data_valid` high on the next cycle, and it never changes a register or starts a transmission. A byte received while `dc_data` is 0 never raises `data_valid`.
- R2: A command byte carries the register address in bits 7:4 and the value in bits 3:0. After the command is taken, register `a` shows the value in `regs_flat[4a+3:4a]` on the next cycle.
- R3: Register 13 bit 0 is the shadow bit. Address nibble 13 always selects register 13. Every other nibble `n` selects register `n` when the shadow bit is 0 and register `16+n` when it is 1.
- R4: When register 0 bit 3 is 1 at the moment a command is taken, the command byte is offered unchanged on `tx_byte`. A write that sets this bit is not itself sent back.
- R5: Address nibble 15 with the shadow bit at 0 stores nothing. It always offers the reply `{4'hF, osc_running, frame_flag, mod_kind[1:0]}`, exactly once, whatever register 0 bit 3 holds.
- R6: A pulse on `rx_frame_err` sets `frame_flag`. The flag stays set until a status reply has carried it, and is then cleared.
- R7: Writing register 1 with bit 0 set loads `baud_div` from `{reg9, reg8}`. The load happens on the next cycle when no byte is sent back, and otherwise only after `tx_done` for that reply. Register 1 bit 0 always reads 0.
- R8: Writing register 1 with bit 3 set restores every register to its reset value and sets `baud_div` to 0x17. The same deferral as R7 applies. Register 1 bit 3 always reads 0.
- R9: Reset values are: reg5=3, reg6=7, reg8=7, reg9=1, reg10=6, reg12=5, reg16=F, reg17=F, reg18=7, reg19=F, reg20=7, reg28=REV_ID, reg30=F and reg31=F. All other registers reset to 0, and `baud_div` resets to 0x17.
- R10: Writes are ignored, and send nothing unless echo is on, for registers 14, 22, 23, 25, 26, 27, 28, 29, 30 and 31 (register 28 is read-only and 14, 22, 23, 25, 26, 27, 29, 30 and 31 are reserved). Register 15 is never stored; nibble 15 is the status request of R5.
- R11: A command received while a reply is waiting for `tx_ready` or `tx_done` is held. It is taken, and written, once that reply completes.
- R12: Once `tx_valid` is high, it and `tx_byte` stay unchanged until a cycle with `tx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | One-cycle strobe: the receiver saw a framing error |
| dc_data | input | 1 | 1 = payload byte, 0 = command byte |
| osc_running | input | 1 | Oscillator status, reported in replies |
| mod_kind | input | 2 | Detected modulation type, reported in replies |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_done | input | 1 | Transmitter finished shifting the last byte |
| data_valid | output | 1 | Payload strobe |
| data_byte | output | 8 | Payload byte |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_byte | output | 8 | Byte offered to the transmitter |
| regs_flat | output | 128 | All 32 registers, register `a` in bits 4a+3:4a |
| baud_div | output | 8 | Baud divisor currently in force |

## Verification
Writes are swept over every address nibble with both values of the shadow bit, using several data patterns. This separates the two banks, shows that nibble 13 is pinned to register 13, and shows that reserved and read-only slots hold their values. Status requests are sent with echo on and off, and before and after a framing error, which shows both that the reply is unconditional and that the flag clears once it has been reported. The baud load and the soft reset are each run with echo on and off: sampling before and after `tx_done` shows whether the action was deferred. Finally, a second command is sent while the transmitter stalls, to show that it is held rather than written early or dropped.

// File: rtl/ctlrf_pkg.sv
package ctlrf_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int ADDR_W = NIB_W + 1;
  localparam int NREG   = 1 << ADDR_W;
  localparam int FLAT_W = NREG * NIB_W;
  localparam int A_ECHO = 0;
  localparam int A_CTL  = 1;
  localparam int A_BDLO = 8;
  localparam int A_BDHI = 9;
  localparam int A_BANK = 13;
  localparam int A_STAT = 15;
  localparam int A_REV  = 28;

  function automatic logic [NIB_W-1:0] reset_value(input int a, input logic [NIB_W-1:0] rev);
    case (a)
      5:       return 4'h3;
      6, 8:    return 4'h7;
      9:       return 4'h1;
      10:      return 4'h6;
      12:      return 4'h5;
      16, 17, 19, 30, 31: return 4'hF;
      18, 20:  return 4'h7;
      A_REV:   return rev;
      default: return '0;
    endcase
  endfunction

  function automatic logic writable(input int a);
    return !(a == 14 || a == A_STAT || a == 22 || a == 23 ||
             (a >= 25 && a <= 27) || a >= A_REV);
  endfunction

  // register 1 holds two action bits (0 and 3) that are never stored
  function automatic logic [NIB_W-1:0] write_mask(input int a);
    return (a == A_CTL) ? 4'b0110 : 4'b1111;
  endfunction
endpackage

// File: rtl/ctlrf_decode.sv
module ctlrf_decode
  import ctlrf_pkg::*;
(
  input  logic [NIB_W-1:0]  addr_nib,
  input  logic              shadow,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_ok,
  output logic              is_status
);
  always_comb begin
    if (addr_nib == NIB_W'(A_BANK)) addr = ADDR_W'(A_BANK);
    else                            addr = {shadow, addr_nib};
    wr_ok     = writable(int'(addr));
    is_status = (addr == ADDR_W'(A_STAT));
  end
endmodule

// File: rtl/ctlrf_bank.sv
module ctlrf_bank
  import ctlrf_pkg::*;
#(
  parameter logic [NIB_W-1:0] REV_ID = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NIB_W-1:0]  wdata,
  input  logic              srst_go,
  input  logic              baud_go,
  output logic [FLAT_W-1:0] regs_flat,
  output logic [BYTE_W-1:0] baud_div
);
  localparam logic [BYTE_W-1:0] BAUD_RST =
    {reset_value(A_BDHI, REV_ID), reset_value(A_BDLO, REV_ID)};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [NIB_W-1:0] q;
    if (writable(i)) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst || srst_go)
          q <= reset_value(i, REV_ID);
        else if (we && waddr == ADDR_W'(i))
          q <= wdata & write_mask(i);
      end
    end else begin : g_ro
      always_ff @(posedge clk) q <= reset_value(i, REV_ID);
    end
    assign regs_flat[i*NIB_W +: NIB_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst || srst_go) baud_div <= BAUD_RST;
    else if (baud_go)   baud_div <= {g_reg[A_BDHI].q, g_reg[A_BDLO].q};
  end
endmodule

// File: rtl/ctlrf_seq.sv
module ctlrf_seq
  import ctlrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              fire,
  output logic [BYTE_W-1:0] fire_byte,
  input  logic              send,
  input  logic [BYTE_W-1:0] send_byte,
  input  logic              want_baud,
  input  logic              want_srst,
  input  logic              tx_ready,
  input  logic              tx_done,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              baud_go,
  output logic              srst_go
);
  logic              hold_v, wait_q, pend_baud, pend_srst, busy, done_now;
  logic [BYTE_W-1:0] hold_b;

  assign busy      = tx_valid | wait_q;
  assign fire      = !busy && (hold_v || cmd_valid);
  assign fire_byte = hold_v ? hold_b : cmd_byte;
  assign done_now  = wait_q & tx_done;
  assign baud_go   = (fire & want_baud & ~send) | (done_now & pend_baud);
  assign srst_go   = (fire & want_srst & ~send) | (done_now & pend_srst);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_b    <= '0;
      wait_q    <= 1'b0;
      pend_baud <= 1'b0;
      pend_srst <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
    end else begin
      if (hold_v && fire) begin
        hold_v <= cmd_valid;
        hold_b <= cmd_byte;
      end else if (cmd_valid && !fire && !hold_v) begin
        hold_v <= 1'b1;
        hold_b <= cmd_byte;
      end
      if (fire && send) begin
        tx_valid  <= 1'b1;
        tx_byte   <= send_byte;
        pend_baud <= want_baud;
        pend_srst <= want_srst;
      end else if (tx_valid && tx_ready) begin
        tx_valid <= 1'b0;
        wait_q   <= 1'b1;
      end else if (done_now) begin
        wait_q    <= 1'b0;
        pend_baud <= 1'b0;
        pend_srst <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_cfg_regfile.sv
module uart_cfg_regfile
  import ctlrf_pkg::*;
#(
  parameter logic [NIB_W-1:0] REV_ID = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_frame_err,
  input  logic              dc_data,
  input  logic              osc_running,
  input  logic [1:0]        mod_kind,
  input  logic              tx_ready,
  input  logic              tx_done,
  output logic              data_valid,
  output logic [BYTE_W-1:0] data_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [FLAT_W-1:0] regs_flat,
  output logic [BYTE_W-1:0] baud_div
);
  logic              fire, wr_ok, is_status, send, want_baud, want_srst;
  logic              baud_go, srst_go, frame_flag, shadow, echo_on;
  logic [BYTE_W-1:0] fire_byte, send_byte;
  logic [ADDR_W-1:0] addr;
  logic [NIB_W-1:0]  status_nib;

  assign shadow  = regs_flat[A_BANK*NIB_W];
  assign echo_on = regs_flat[A_ECHO*NIB_W + 3];

  always_ff @(posedge clk) begin
    if (rst) begin
      data_valid <= 1'b0;
      data_byte  <= '0;
    end else begin
      data_valid <= rx_valid & dc_data;
      if (rx_valid && dc_data) data_byte <= rx_byte;
    end
  end

  ctlrf_seq u_seq (
    .clk, .rst,
    .cmd_valid(rx_valid & ~dc_data), .cmd_byte(rx_byte),
    .fire, .fire_byte,
    .send, .send_byte, .want_baud, .want_srst,
    .tx_ready, .tx_done, .tx_valid, .tx_byte,
    .baud_go, .srst_go
  );

  ctlrf_decode u_dec (
    .addr_nib(fire_byte[BYTE_W-1:NIB_W]), .shadow,
    .addr, .wr_ok, .is_status
  );

  assign status_nib = {osc_running, frame_flag, mod_kind};
  assign want_baud  = wr_ok && addr == ADDR_W'(A_CTL) && fire_byte[0];
  assign want_srst  = wr_ok && addr == ADDR_W'(A_CTL) && fire_byte[3];
  assign send       = is_status | echo_on;
  assign send_byte  = is_status ? {{NIB_W{1'b1}}, status_nib} : fire_byte;

  always_ff @(posedge clk) begin
    if (rst)                    frame_flag <= 1'b0;
    else if (rx_frame_err)      frame_flag <= 1'b1;
    else if (fire && is_status) frame_flag <= 1'b0;
  end

  ctlrf_bank #(.REV_ID(REV_ID)) u_bank (
    .clk, .rst,
    .we(fire & wr_ok), .waddr(addr), .wdata(fire_byte[NIB_W-1:0]),
    .srst_go, .baud_go,
    .regs_flat, .baud_div
  );
endmodule

// File: rtl/ctlrf_chk.sv
module ctlrf_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       dc_data,
  input logic       data_valid,
  input logic [7:0] data_byte,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic [3:0] reg1,
  input logic [7:0] baud_div
);
  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && dc_data |=> data_valid && data_byte == $past(rx_byte));
  // R1
  cmd_not_data_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !dc_data |=> !data_valid);
  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
  // R7 R8
  action_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !reg1[0] && !reg1[3]);
  // R9
  baud_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> baud_div == 8'h17);
endmodule

bind uart_cfg_regfile ctlrf_chk u_chk (
  .clk, .rst, .rx_valid, .rx_byte, .dc_data, .data_valid, .data_byte,
  .tx_valid, .tx_ready, .tx_byte, .reg1(regs_flat[7:4]), .baud_div
);

// File: tb/tb_uart_cfg_regfile.sv
module tb_uart_cfg_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] REV = 4'h1;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 0, rx_frame_err = 0, dc_data = 0, osc_running = 1;
  logic tx_ready = 0, tx_done = 0;
  logic [7:0] rx_byte = 0;
  logic [1:0] mod_kind = 2'b10;
  logic data_valid, tx_valid;
  logic [7:0] data_byte, tx_byte, baud_div;
  logic [127:0] regs_flat;

  int n_run = 0, n_fail = 0;
  bit ended = 0;
  logic [3:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_cfg_regfile #(.REV_ID(REV)) dut (
    .clk, .rst, .rx_valid, .rx_byte, .rx_frame_err, .dc_data, .osc_running,
    .mod_kind, .tx_ready, .tx_done, .data_valid, .data_byte, .tx_valid,
    .tx_byte, .regs_flat, .baud_div
  );

  // reset values taken from R9
  function automatic logic [3:0] rv(input int a);
    case (a)
      5: return 4'h3;  6: return 4'h7;  8: return 4'h7;  9: return 4'h1;
      10: return 4'h6; 12: return 4'h5; 16: return 4'hF; 17: return 4'hF;
      18: return 4'h7; 19: return 4'hF; 20: return 4'h7; 28: return REV;
      30: return 4'hF; 31: return 4'hF;
      default: return 4'h0;
    endcase
  endfunction

  // ignored slots listed in R10
  function automatic bit ignored(input int a);
    return a == 14 || a == 15 || a == 22 || a == 23 || (a >= 25 && a <= 27) || a >= 28;
  endfunction

  function automatic logic [127:0] model_flat();
    logic [127:0] f;
    for (int i = 0; i < 32; i++) f[i*4 +: 4] = model[i];
    return f;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic dc);
    @(negedge clk);
    rx_valid = 1; rx_byte = b; dc_data = dc;
    @(negedge clk);
    rx_valid = 0; dc_data = 0;
  endtask

  task automatic tx_accept(input string req, input logic [7:0] exp);
    for (int i = 0; i < 20 && !tx_valid; i++) @(negedge clk);
    check(req, {127'd0, tx_valid}, 128'd1);
    check(req, {120'd0, tx_byte}, {120'd0, exp});
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic tx_finish();
    @(negedge clk);
    tx_done = 1;
    @(negedge clk);
    tx_done = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = rv(i);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check("R9 regs", regs_flat, model_flat());
    check("R9 baud", {120'd0, baud_div}, {120'd0, 8'h17});
    check("R12 idle", {126'd0, tx_valid, data_valid}, 128'd0);

    // R1 payload bytes pass through and touch nothing
    for (int v = 0; v < 256; v += 37) begin
      send(8'(v), 1'b1);
      check("R1 strobe", {127'd0, data_valid}, 128'd1);
      check("R1 byte", {120'd0, data_byte}, {120'd0, 8'(v)});
      check("R1 regs", regs_flat, model_flat());
      check("R1 no tx", {127'd0, tx_valid}, 128'd0);
    end

    // R2 R10 sweep of the low bank
    for (int n = 2; n < 15; n++) begin
      if (n == 13) continue;
      for (int k = 0; k < 4; k++) begin
        logic [3:0] d;
        d = 4'((k * 5 + n) ^ 4'hA);
        send({4'(n), d}, 1'b0);
        if (!ignored(n)) model[n] = d;
        check("R2 R10 low bank", regs_flat, model_flat());
        check("R2 no data strobe", {127'd0, data_valid}, 128'd0);
      end
    end

    // R3 shadow bank sweep, nibble 13 stays on register 13
    send(8'hD1, 1'b0); model[13] = 4'h1;
    check("R3 shadow set", regs_flat, model_flat());
    for (int n = 0; n < 16; n++) begin
      if (n == 13) continue;
      for (int k = 0; k < 2; k++) begin
        logic [3:0] d;
        d = k ? 4'h9 : 4'h6;
        send({4'(n), d}, 1'b0);
        if (!ignored(16 + n)) model[16 + n] = d;
        check("R3 R10 high bank", regs_flat, model_flat());
        check("R10 no reply", {127'd0, tx_valid}, 128'd0);
      end
    end
    send(8'hD0, 1'b0); model[13] = 4'h0;
    check("R3 shadow clear", regs_flat, model_flat());

    // R5 R6 status with echo off, after a framing error
    @(negedge clk); rx_frame_err = 1; @(negedge clk); rx_frame_err = 0;
    send(8'hF3, 1'b0);
    tx_accept("R5 R6 status err", 8'hFE);
    tx_finish();
    check("R5 no store", regs_flat, model_flat());
    send(8'hF0, 1'b0);
    tx_accept("R6 flag cleared", 8'hFA);
    tx_finish();

    // R7 immediate baud load
    send(8'h83, 1'b0); model[8] = 4'h3;
    send(8'h90, 1'b0); model[9] = 4'h0;
    check("R7 no early load", {120'd0, baud_div}, {120'd0, 8'h17});
    send(8'h11, 1'b0);
    check("R7 immediate", {120'd0, baud_div}, {120'd0, 8'h03});
    check("R7 bit clears", regs_flat, model_flat());

    // R4 echo
    send(8'h08, 1'b0); model[0] = 4'h8;
    check("R4 enabling write not echoed", {127'd0, tx_valid}, 128'd0);
    send(8'h85, 1'b0); model[8] = 4'h5;
    tx_accept("R4 echo", 8'h85);
    tx_finish();
    send(8'hF0, 1'b0);
    tx_accept("R5 status with echo", 8'hFA);
    tx_finish();
    check("R5 single reply", {127'd0, tx_valid}, 128'd0);

    // R7 deferred baud load
    send(8'h92, 1'b0); model[9] = 4'h2;
    tx_accept("R4 echo reg9", 8'h92);
    tx_finish();
    send(8'h11, 1'b0);
    tx_accept("R7 echo", 8'h11);
    check("R7 deferred", {120'd0, baud_div}, {120'd0, 8'h03});
    tx_finish();
    check("R7 applied after done", {120'd0, baud_div}, {120'd0, 8'h25});
    check("R7 regs", regs_flat, model_flat());

    // R11 held command
    send(8'h84, 1'b0); model[8] = 4'h4;
    send(8'h86, 1'b0);
    check("R11 not written early", regs_flat, model_flat());
    tx_accept("R11 first echo", 8'h84);
    tx_finish();
    tx_accept("R11 held echo", 8'h86);
    model[8] = 4'h6;
    check("R11 held written", regs_flat, model_flat());
    tx_finish();

    // R8 soft reset deferred behind echo
    send(8'h18, 1'b0);
    tx_accept("R8 echo", 8'h18);
    check("R8 deferred regs", regs_flat, model_flat());
    check("R8 deferred baud", {120'd0, baud_div}, {120'd0, 8'h25});
    tx_finish();
    for (int i = 0; i < 32; i++) model[i] = rv(i);
    check("R8 R9 regs after", regs_flat, model_flat());
    check("R8 baud after", {120'd0, baud_div}, {120'd0, 8'h17});

    // R8 immediate soft reset with echo off
    send(8'h85, 1'b0); model[8] = 4'h5;
    check("R2 write", regs_flat, model_flat());
    send(8'h18, 1'b0); model[8] = 4'h7;
    check("R8 immediate", regs_flat, model_flat());
    check("R8 no tx", {127'd0, tx_valid}, 128'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule